// File: doc/BRIEF.md
# Peripheral Bus Access Sequencer

This block sits on the host side of an asynchronous 8-bit peripheral bus that has a separate active-low read strobe, a separate active-low write strobe and an active-low chip select. A client hands it one access at a time over a valid/ready command port. Each access names its kind: a command-register write, a data-register access (read or write, with a flag saying that a read targets the coefficient RAM), a receive-buffer read, or an indirect-register access (read or write). The block then drives the address, chip select, strobe and write-data enable. Every setup, pulse, hold and recovery interval is a count of clock cycles derived from nanosecond parameters and a clock-period parameter, rounded up.

The idle gap that is required between one strobe rising and the next strobe falling depends on the pair of accesses. The usual gap is 200 ns. A coefficient-RAM data read that directly follows a command write needs 450 ns. Two receive-buffer reads in a row need a total period of 480 ns. The block learns the kind of the next access only when that access is accepted. It therefore meets these gaps by holding the new access in its address-setup phase, with chip select already low, until the gap has elapsed.

An indirect read and an indirect write may not follow one another unless a command write is issued between them. A request that would break this rule is answered with an error response and never reaches the bus. A completed access is answered with a one-cycle response that carries the captured read data.

Top module: `pbs_access_seq`

## Requirements
- R1: Every read or write strobe stays low for PW = max(ceil(200/CLK_NS), ceil(100/CLK_NS), ceil(80/CLK_NS)) cycles, which is 20 at the default 10 ns clock.
- R2: Between a strobe rising and the next strobe falling there are at least REC = ceil(200/CLK_NS) = 20 cycles with both strobes high. When no longer gap applies, the next strobe falls exactly max(accept + AS, last low cycle + 1 + REC).
- R3: A data-register read with req_coef=1 that directly follows an issued command write waits for a gap of ceil(450/CLK_NS) = 45 cycles. The same read after any other kind of access waits for REC only.
- R4: A receive-buffer read that directly follows an issued receive-buffer read waits for a gap of max(REC, ceil(480/CLK_NS) - PW) = 28 cycles.
- R5: The address is registered when a request is accepted. It is stable for the whole chip-select-low interval, it is valid for at least AS = ceil(20/CLK_NS) = 2 cycles before the strobe falls, and it is held for AH = max(1, ceil(10/CLK_NS)) = 1 cycle after the strobe rises.
- R6: For a write, bus_doe is high and bus_dout carries the accepted data for the whole chip-select-low interval, which includes the cycles after the write strobe rises. For a read, bus_doe stays low. The two strobes are never low together.
- R7: A read captures bus_din on the last cycle of the strobe. rsp_valid pulses for one cycle on the first cycle after the strobe rises, and rsp_rdata holds the captured byte during that cycle. A write produces the same pulse without data.
- R8: The request kinds are encoded on req_kind as 0 command write, 1 data access, 2 receive-buffer read, 3 indirect access. An indirect access whose direction (req_write) is opposite to the last issued indirect access is rejected: rsp_valid and rsp_err pulse on the cycle after acceptance, and the bus stays idle.
- R9: Chip select is low from the first setup cycle through the last hold cycle. It is never high while a strobe is low, and it rises only after both strobes are high.
- R10: req_ready is high exactly when no access is in progress. It falls on the cycle after acceptance and rises again on the cycle after the last hold cycle. Only one access is ever outstanding.
- R11: During reset and after it, with no request, bus_cs_n, bus_rd_n and bus_wr_n are high, bus_doe and rsp_valid are low, and req_ready is high.
- R12: req_write is ignored for a command write, which is always a write, and for a receive-buffer read, which is always a read.
- R13: An issued command write clears the indirect-direction history. After it, an indirect access of either direction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | Access kind (0 cmd write, 1 data, 2 rx buffer, 3 indirect) |
| req_write | input | 1 | Direction for data and indirect accesses (1 = write) |
| req_coef | input | 1 | Data read targets the coefficient RAM |
| req_addr | input | ADDR_W | Peripheral register address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion or rejection pulse |
| rsp_err | output | 1 | Request rejected by the ordering rule |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Bus address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_doe | output | 1 | Drive enable for bus_dout |
| bus_dout | output | DATA_W | Write data toward the peripheral |
| bus_din | input | DATA_W | Read data from the peripheral |

## Verification
The assertions assume that reset is held low for at least one clock at the start. They also assume that a requester keeps req_valid and its fields steady until the handshake. They do not constrain bus_din, because the block only samples it. The bench keeps to these assumptions: it holds reset for five cycles and drives each request from the falling clock edge until req_ready has been seen. Its peripheral model returns valid data only once the read strobe has been low for the access time, so a capture taken too early shows up as a wrong byte.

// File: rtl/pbs_pkg.sv
// Shared types and helpers for the peripheral bus access sequencer.
// Assumes: nanosecond values and the clock period are positive integers.
package pbs_pkg;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_DATA  = 2'd1,
        KIND_RXBUF = 2'd2,
        KIND_INDIR = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        IND_NONE = 2'd0,
        IND_RD   = 2'd1,
        IND_WR   = 2'd2
    } ind_hist_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      wr;
        logic      coef;
    } acc_desc_t;

    // Round a nanosecond interval up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbs_order_guard.sv
// Ordering guard: remembers what the last issued access was, decides whether
// a new request breaks the indirect read/write mixing rule, and picks the
// strobe-to-strobe gap the new access needs.
// Assumes: desc is already normalised (direction forced for fixed kinds) and
// issue pulses once per access that really goes onto the bus.
module pbs_order_guard
    import pbs_pkg::*;
#(
    parameter int GAP_W    = 6,
    parameter int REC_CYC  = 20,
    parameter int COEF_CYC = 45,
    parameter int RXG_CYC  = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_desc_t        desc,
    input  logic             issue,
    output logic             reject,
    output logic [GAP_W-1:0] need_gap
);

    ind_hist_e hist;
    logic      prev_cmd;
    logic      prev_rx;

    // Record the kind of the last issued access and the indirect direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist     <= IND_NONE;
            prev_cmd <= 1'b0;
            prev_rx  <= 1'b0;
        end else if (issue) begin
            prev_cmd <= (desc.kind == KIND_CMD);
            prev_rx  <= (desc.kind == KIND_RXBUF);
            if (desc.kind == KIND_CMD)
                hist <= IND_NONE;
            else if (desc.kind == KIND_INDIR)
                hist <= desc.wr ? IND_WR : IND_RD;
        end
    end

    // Flag a request that would mix indirect directions without a command write.
    always_comb begin
        reject = (desc.kind == KIND_INDIR) &&
                 ((desc.wr && hist == IND_RD) || (!desc.wr && hist == IND_WR));
    end

    // Select the required idle gap from the (previous, next) pair of kinds.
    always_comb begin
        if (desc.kind == KIND_DATA && !desc.wr && desc.coef && prev_cmd)
            need_gap = GAP_W'(COEF_CYC);
        else if (desc.kind == KIND_RXBUF && prev_rx)
            need_gap = GAP_W'(RXG_CYC);
        else
            need_gap = GAP_W'(REC_CYC);
    end

endmodule

// File: rtl/pbs_gap_timer.sv
// Gap timer: counts cycles with both strobes high since the last strobe-low
// cycle, saturating at GAP_MAX. Starts saturated so the first access after
// reset sees no pending recovery.
// Assumes: GAP_MAX fits in GAP_W bits.
module pbs_gap_timer #(
    parameter int GAP_W   = 6,
    parameter int GAP_MAX = 45
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_low,
    output logic [GAP_W-1:0] gap_cnt
);

    // Clear on a strobe-low cycle, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_cnt <= GAP_W'(GAP_MAX);
        else if (strobe_low)
            gap_cnt <= '0;
        else if (gap_cnt != GAP_W'(GAP_MAX))
            gap_cnt <= gap_cnt + 1'b1;
    end

endmodule

// File: rtl/pbs_phase_fsm.sv
// Access phase machine: walks one access through address setup (stretched
// until the recovery gap is met), strobe pulse and hold, drives the bus
// pins from its state, captures read data and pulses done.
// Assumes: start only while idle; need_gap >= 1; all cycle counts >= 1.
module pbs_phase_fsm
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int AS_CYC = 2,
    parameter int PW_CYC = 20,
    parameter int AH_CYC = 1,
    parameter int GAP_W  = 6,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              start_wr,
    input  logic [GAP_W-1:0]  start_need,
    input  logic [GAP_W-1:0]  gap_cnt,
    input  logic [DATA_W-1:0] bus_din,
    output logic              idle,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_doe,
    output logic [DATA_W-1:0] bus_dout
);

    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic              acc_wr;
    logic [GAP_W-1:0]  need;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [GAP_W:0]    gap_next;
    logic              setup_ok;
    logic              gap_ok;

    // Gap reached once the strobe falls on the next cycle.
    always_comb begin
        gap_next = {1'b0, gap_cnt} + 1'b1;
        gap_ok   = (gap_next >= {1'b0, need});
        setup_ok = (cnt >= CNT_W'(AS_CYC - 1));
    end

    // Sequence the phases, hold the access fields and capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            acc_wr  <= 1'b0;
            need    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_SETUP;
                        cnt     <= '0;
                        acc_wr  <= start_wr;
                        need    <= start_need;
                        addr_q  <= start_addr;
                        wdata_q <= start_wdata;
                    end
                end
                PH_SETUP: begin
                    if (setup_ok && gap_ok) begin
                        phase <= PH_STROBE;
                        cnt   <= '0;
                    end else if (!setup_ok) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt == CNT_W'(PW_CYC - 1)) begin
                        phase <= PH_HOLD;
                        cnt   <= '0;
                        done  <= 1'b1;
                        if (!acc_wr)
                            rdata <= bus_din;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == CNT_W'(AH_CYC - 1))
                        phase <= PH_IDLE;
                    else
                        cnt <= cnt + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Decode bus pins from the phase and the held access fields.
    always_comb begin
        idle     = (phase == PH_IDLE);
        bus_cs_n = idle;
        bus_rd_n = !(phase == PH_STROBE && !acc_wr);
        bus_wr_n = !(phase == PH_STROBE && acc_wr);
        bus_doe  = acc_wr && !idle;
        bus_addr = addr_q;
        bus_dout = wdata_q;
    end

endmodule

// File: rtl/pbs_access_seq.sv
// Peripheral bus access sequencer (top). Accepts one access at a time on a
// valid/ready port, normalises its direction, checks the indirect ordering
// rule, selects the recovery gap and runs the access on the strobe bus.
// Assumes: requester holds fields steady while req_valid is high; all time
// parameters are in nanoseconds and CLK_NS is the clock period.
module pbs_access_seq
    import pbs_pkg::*;
#(
    parameter int CLK_NS          = 10,
    parameter int ADDR_W          = 3,
    parameter int DATA_W          = 8,
    parameter int PULSE_NS        = 200,
    parameter int RECOV_NS        = 200,
    parameter int COEF_GAP_NS     = 450,
    parameter int RXBUF_PERIOD_NS = 480,
    parameter int ADDR_SETUP_NS   = 20,
    parameter int ADDR_HOLD_NS    = 10,
    parameter int DATA_SETUP_NS   = 100,
    parameter int DATA_HOLD_NS    = 10,
    parameter int READ_ACC_NS     = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic              req_coef,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_doe,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din
);

    localparam int PW_CYC   = imax(imax(ns_to_cyc(PULSE_NS, CLK_NS), ns_to_cyc(DATA_SETUP_NS, CLK_NS)),
                                   ns_to_cyc(READ_ACC_NS, CLK_NS));
    localparam int AS_CYC   = imax(1, ns_to_cyc(ADDR_SETUP_NS, CLK_NS));
    localparam int AH_CYC   = imax(1, imax(ns_to_cyc(ADDR_HOLD_NS, CLK_NS), ns_to_cyc(DATA_HOLD_NS, CLK_NS)));
    localparam int REC_CYC  = imax(1, ns_to_cyc(RECOV_NS, CLK_NS));
    localparam int COEF_CYC = imax(REC_CYC, ns_to_cyc(COEF_GAP_NS, CLK_NS));
    localparam int RXG_CYC  = imax(REC_CYC, ns_to_cyc(RXBUF_PERIOD_NS, CLK_NS) - PW_CYC);
    localparam int GAP_MAX  = imax(COEF_CYC, RXG_CYC);
    localparam int GAP_W    = $clog2(GAP_MAX + 1);
    localparam int CNT_W    = $clog2(imax(PW_CYC, imax(AS_CYC, AH_CYC)) + 1);

    acc_desc_t        desc;
    logic             accept;
    logic             issue;
    logic             reject;
    logic [GAP_W-1:0] need_gap;
    logic [GAP_W-1:0] gap_cnt;
    logic             fsm_idle;
    logic             fsm_done;

    // Normalise the request: fixed-direction kinds ignore req_write.
    always_comb begin
        desc.kind = acc_kind_e'(req_kind);
        desc.coef = req_coef;
        unique case (desc.kind)
            KIND_CMD:   desc.wr = 1'b1;
            KIND_RXBUF: desc.wr = 1'b0;
            default:    desc.wr = req_write;
        endcase
        req_ready = fsm_idle;
        accept    = req_valid && req_ready;
        issue     = accept && !reject;
        rsp_valid = fsm_done || rsp_err;
    end

    // Register the one-cycle rejection response.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_err <= 1'b0;
        else
            rsp_err <= accept && reject;
    end

    pbs_order_guard #(
        .GAP_W   (GAP_W),
        .REC_CYC (REC_CYC),
        .COEF_CYC(COEF_CYC),
        .RXG_CYC (RXG_CYC)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .desc    (desc),
        .issue   (issue),
        .reject  (reject),
        .need_gap(need_gap)
    );

    pbs_gap_timer #(
        .GAP_W  (GAP_W),
        .GAP_MAX(GAP_MAX)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_low(!(bus_rd_n && bus_wr_n)),
        .gap_cnt   (gap_cnt)
    );

    pbs_phase_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .AS_CYC(AS_CYC),
        .PW_CYC(PW_CYC),
        .AH_CYC(AH_CYC),
        .GAP_W (GAP_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (issue),
        .start_addr (req_addr),
        .start_wdata(req_wdata),
        .start_wr   (desc.wr),
        .start_need (need_gap),
        .gap_cnt    (gap_cnt),
        .bus_din    (bus_din),
        .idle       (fsm_idle),
        .done       (fsm_done),
        .rdata      (rsp_rdata),
        .bus_addr   (bus_addr),
        .bus_cs_n   (bus_cs_n),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_doe    (bus_doe),
        .bus_dout   (bus_dout)
    );

endmodule

// File: rtl/pbs_access_seq_chk.sv
// Protocol checker for the access sequencer, bound to the top module.
// Measures strobe pulse width and strobe-to-strobe gaps with its own counters.
// Assumes: reset is held low for at least one clock at the start.
module pbs_access_seq_chk
    import pbs_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int ADDR_W   = 3,
    parameter int PULSE_NS = 200,
    parameter int RECOV_NS = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_doe
);

    localparam int PW_MIN  = ns_to_cyc(PULSE_NS, CLK_NS);
    localparam int REC_MIN = ns_to_cyc(RECOV_NS, CLK_NS);

    logic        strobe_hi;
    logic [15:0] lo_cnt;
    logic [15:0] hi_cnt;

    always_comb strobe_hi = bus_rd_n && bus_wr_n;

    // Count consecutive strobe-low and strobe-high cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= 16'hFFFF;
        end else begin
            lo_cnt <= strobe_hi ? 16'd0 : lo_cnt + 1'b1;
            if (!strobe_hi)
                hi_cnt <= '0;
            else if (hi_cnt != 16'hFFFF)
                hi_cnt <= hi_cnt + 1'b1;
        end
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_hi) |-> lo_cnt >= 16'(PW_MIN)); // R1
    AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_hi) |-> hi_cnt >= 16'(REC_MIN)); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr)); // R5
    AST_WRITE_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_doe); // R6
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (bus_rd_n || bus_wr_n)); // R6
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_hi |-> !bus_cs_n); // R9
    AST_CS_RISE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> $past(strobe_hi)); // R9
    AST_REJECT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && bus_cs_n && strobe_hi)); // R8
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!bus_cs_n || rsp_err)); // R10

endmodule

bind pbs_access_seq pbs_access_seq_chk #(
    .CLK_NS  (CLK_NS),
    .ADDR_W  (ADDR_W),
    .PULSE_NS(PULSE_NS),
    .RECOV_NS(RECOV_NS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .bus_addr (bus_addr),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_doe  (bus_doe)
);

// File: tb/pbs_access_seq_bench.sv
// Bench: a behavioural timeline model predicts every bus pin and response
// each cycle; a simple peripheral returns data only after the access time.
module pbs_access_seq_bench;

    localparam int CLK = 10;
    localparam int PW  = (200 + CLK - 1) / CLK;
    localparam int AS  = (20 + CLK - 1) / CLK;
    localparam int AH  = 1;
    localparam int REC = (200 + CLK - 1) / CLK;
    localparam int CO  = (450 + CLK - 1) / CLK;
    localparam int RXG = (480 + CLK - 1) / CLK - PW;
    localparam int ACC = (80 + CLK - 1) / CLK;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = 2'd0;
    logic       req_write = 1'b0;
    logic       req_coef = 1'b0;
    logic [2:0] req_addr = 3'd0;
    logic [7:0] req_wdata = 8'd0;
    logic       rsp_valid, rsp_err;
    logic [7:0] rsp_rdata;
    logic [2:0] bus_addr;
    logic       bus_cs_n, bus_rd_n, bus_wr_n, bus_doe;
    logic [7:0] bus_dout;
    logic [7:0] bus_din = 8'hEE;

    pbs_access_seq u_pbs_access_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_write(req_write), .req_coef(req_coef),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_doe(bus_doe), .bus_dout(bus_dout), .bus_din(bus_din)
    );

    always #5 clk = ~clk;

    int    cyc = 0;
    int    vectors = 0;
    int    miscompares = 0;
    bit    chk_on = 1'b0;
    int    s_A = -1000, s_F = -1000, s_E = -2000;
    bit    s_wr = 1'b0;
    logic [2:0] s_addr = 3'd0;
    logic [7:0] s_data = 8'd0;
    string s_tag = "R11";
    int    err_at = -1;
    int    last_low = -1000;
    bit    prev_cmd = 1'b0, prev_rx = 1'b0;
    int    hist = 0;
    int    rdlo = 0;

    function automatic logic [7:0] periph_val(input logic [2:0] a);
        return ({5'd0, a} * 8'd35) ^ 8'h5A;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Peripheral: data valid only after the read strobe has been low ACC cycles.
    always @(negedge clk) begin
        if (!bus_rd_n) rdlo = rdlo + 1; else rdlo = 0;
        bus_din = (rdlo >= ACC) ? periph_val(bus_addr) : 8'hEE;
    end

    task automatic chk1(input logic act, input logic exp, input string what);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s cyc %0d: actual %b expected %b", what, cyc, act, exp);
        end
    endtask

    task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string what);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s cyc %0d: actual %h expected %h", what, cyc, act, exp);
        end
    endtask

    // Compare every output against the timeline model on each falling edge.
    always @(negedge clk) begin
        if (chk_on) begin
            bit in_cs, in_str, exp_rsp;
            string t, tc;
            vectors++;
            in_cs  = (cyc >= s_A) && (cyc <= s_E);
            in_str = (cyc >= s_F) && (cyc <= s_F + PW - 1);
            exp_rsp = (cyc == s_F + PW) || (cyc == err_at);
            t  = !rst_n ? "R11" : s_tag;
            tc = !rst_n ? "R11" : "R9";
            chk1(bus_cs_n, !in_cs, {tc, " cs_n"});
            chk1(bus_rd_n, !(in_str && !s_wr), {t, " rd_n"});
            chk1(bus_wr_n, !(in_str && s_wr), {t, " wr_n"});
            chk1(bus_doe, in_cs && s_wr, !rst_n ? "R11 doe" : "R6 doe");
            chk1(req_ready, !in_cs, !rst_n ? "R11 ready" : "R10 ready");
            chk1(rsp_valid, exp_rsp, (cyc == err_at) ? "R8 rsp_valid" : "R7 rsp_valid");
            chk1(rsp_err, cyc == err_at, "R8 rsp_err");
            if (in_cs) chk8({5'd0, bus_addr}, {5'd0, s_addr}, "R5 addr");
            if (in_cs && s_wr) chk8(bus_dout, s_data, "R6 dout");
            if (cyc == s_F + PW && !s_wr) chk8(rsp_rdata, periph_val(s_addr), "R7 rdata");
        end
    end

    // Issue one request and advance the timeline model at the handshake.
    task automatic do_req(input logic [1:0] k, input logic w, input logic c,
                          input logic [2:0] a, input logic [7:0] d, input string tag);
        int A, F, need;
        bit wr, rej;
        @(negedge clk);
        req_kind = k; req_write = w; req_coef = c; req_addr = a; req_wdata = d;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        A   = cyc + 1;
        wr  = (k == 2'd0) ? 1'b1 : (k == 2'd2) ? 1'b0 : w;
        rej = (k == 2'd3) && ((wr && hist == 1) || (!wr && hist == 2));
        if (rej) begin
            err_at = A;
        end else begin
            need = REC;
            if (k == 2'd1 && !wr && c && prev_cmd) need = CO;
            else if (k == 2'd2 && prev_rx) need = (RXG > REC) ? RXG : REC;
            F = A + AS;
            if (last_low + 1 + need > F) F = last_low + 1 + need;
            s_A = A; s_F = F; s_E = F + PW + AH - 1;
            s_wr = wr; s_addr = a; s_data = d; s_tag = tag;
            last_low = F + PW - 1;
            prev_cmd = (k == 2'd0);
            prev_rx  = (k == 2'd2);
            if (k == 2'd0) hist = 0;
            if (k == 2'd3) hist = wr ? 2 : 1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        @(posedge clk);
        @(posedge clk);
        chk_on = 1'b1;                                       // R11 checked during reset
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);                           // R11 idle after reset
        do_req(2'd1, 1'b1, 1'b0, 3'd1, 8'hA5, "R1");         // R1 write pulse, R6
        do_req(2'd1, 1'b0, 1'b0, 3'd2, 8'h00, "R2");         // R2 base gap, R7 read
        do_req(2'd0, 1'b0, 1'b0, 3'd0, 8'h3C, "R12");        // R12 cmd forced write
        do_req(2'd1, 1'b0, 1'b1, 3'd5, 8'h00, "R3");         // R3 coef read after cmd
        do_req(2'd1, 1'b0, 1'b1, 3'd6, 8'h00, "R3");         // R3 coef read, base gap
        do_req(2'd2, 1'b1, 1'b0, 3'd7, 8'h00, "R12");        // R12 rx forced read
        do_req(2'd2, 1'b0, 1'b0, 3'd7, 8'h00, "R4");         // R4 rx after rx
        do_req(2'd1, 1'b1, 1'b0, 3'd3, 8'h81, "R2");
        do_req(2'd2, 1'b0, 1'b0, 3'd4, 8'h00, "R2");         // rx after write: base gap
        do_req(2'd3, 1'b0, 1'b0, 3'd2, 8'h00, "R8");         // indirect read issued
        do_req(2'd3, 1'b1, 1'b0, 3'd2, 8'h11, "R8");         // R8 rejected write
        do_req(2'd3, 1'b0, 1'b0, 3'd3, 8'h00, "R8");         // same direction accepted
        do_req(2'd0, 1'b1, 1'b0, 3'd0, 8'h22, "R13");        // clears history
        do_req(2'd3, 1'b1, 1'b0, 3'd1, 8'h44, "R13");        // R13 write now accepted
        do_req(2'd3, 1'b0, 1'b0, 3'd1, 8'h00, "R8");         // R8 rejected read
        do_req(2'd3, 1'b1, 1'b0, 3'd6, 8'h66, "R8");         // write again accepted
        repeat (70) @(negedge clk);
        do_req(2'd1, 1'b0, 1'b1, 3'd5, 8'h00, "R5");         // R5 gap long past: setup only
        do_req(2'd1, 1'b1, 1'b0, 3'd0, 8'hFF, "R6");         // R6 write data held
        repeat (60) @(negedge clk);
        finish_run();
    end

endmodule